// File: doc/BRIEF.md
# Serial-Controlled Successive-Approximation Converter Core

This block is the digital controller of an 8-bit successive-approximation analog-to-digital converter that a host drives over a three-wire serial link. The host pulls chip select low and clocks in a start bit and a short channel word. The core then points an external analog multiplexer at the requested input pair. It runs a binary search on an external DAC ladder, reading one comparator bit per clock. The result streams back to the host while the search runs.

The result leaves MSB-first, one bit per clock, after a single settling period in which the data line is driven low. It is then replayed LSB-first. The four-channel build replays it at once. The eight-channel build holds the LSB on the line until the host lowers a hold pin. Data output changes on falling clock edges so that the host can sample on rising edges. Raising chip select abandons any transaction and floats the data line.

Top module: `sar_serial_adc`

## Requirements
- R1: While `cs_n` is high, at the next rising edge `busy` goes low and `trial` goes to zero. `dout_oe` is low as long as `cs_n` is high. Once a conversion has ended, a new start bit is ignored until `cs_n` has gone high and low again.
- R2: With `cs_n` low and no transaction under way, `di` is sampled on each rising edge and zeros are skipped. The first 1 is the start bit.
- R3: Eight-channel build: after the start bit, four bits arrive in this order: single-ended flag (1 = single-ended), odd flag, select bit 1, select bit 0. Single-ended gives `mux_pos` = {sel1, sel0, odd}, `mux_single`=1 and `mux_neg`=0. Differential gives `mux_pos` = {sel1, sel0, odd}, `mux_neg` = {sel1, sel0, ~odd} and `mux_single`=0.
- R4: Four-channel build: after the start bit, three bits arrive in this order: single-ended flag, odd flag, select bit. `mux_pos` = {sel, odd} and `mux_neg` = {sel, ~odd} in differential mode.
- R5: `busy` rises on the rising edge that samples the last address bit and stays high for exactly eight clock periods. `trial` is 8'h80 when `busy` rises. Each later `trial` value changes at most two bits.
- R6: At the first falling edge after `busy` rises, `dout_oe` goes high and `dout` is low for one full clock period.
- R7: The following eight falling edges drive the result bits MSB-first on `dout`. `busy` is low by the time the LSB is on the line.
- R8: With `comp_hi`=1 meaning that the selected input is at or above `trial`, the result is the input difference clamped to 0..255. A positive input below the negative input gives all zeros.
- R9: `di` has no effect on the result or on the output stream while a conversion or replay is under way.
- R10: Four-channel build: right after the LSB, bits 1 through 7 follow on successive falling edges. The next falling edge floats the line (`dout_oe`=0).
- R11: Eight-channel build: while `lsb_hold` is high after the search, the LSB stays on `dout`. Each rising edge that samples `lsb_hold` low moves the next bit (bits 1 through 7 in turn) onto `dout`. The rising edge after bit 7 floats the line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock from the host |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select; high clears the core |
| di | input | 1 | Serial start bit and address word |
| lsb_hold | input | 1 | Eight-channel build: high holds the LSB, low steps the LSB-first replay |
| comp_hi | input | 1 | Comparator: selected input is at or above the trial level |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Drive enable for `dout` (low = high impedance) |
| busy | output | 1 | Conversion in progress |
| mux_single | output | 1 | Single-ended (1) or differential (0) input mode |
| mux_pos | output | $clog2(NUM_CH) | Channel used as positive input |
| mux_neg | output | $clog2(NUM_CH) | Channel used as negative input in differential mode |
| trial | output | RES_W | Trial code to the DAC ladder |

## Verification
The two functions that share an edge are the end of the binary search and the start of the LSB-first replay. On the edge that decides bit 0, `busy` drops and the controller starts the replay. On the very next edge the replay may already step on, if `lsb_hold` is low or the build replays by itself. The bench lowers `lsb_hold` before the search ends as well as after several hold periods. It requires bit 0 to appear exactly once and bit 1 to follow with no gap and no repeat, while `busy` is already low. Chip select rising mid-conversion is the second overlap. It is judged by the line floating at once and the search registers being empty one edge later.

// File: rtl/sar_adc_pkg.sv
// Package: shared types for the serial successive-approximation core.
// Assumes: one controller instance per package user; no run-time state here.
package sar_adc_pkg;

    // Transaction phase of the serial controller.
    typedef enum logic [2:0] {
        PH_IDLE,    // waiting for the start bit
        PH_ADDR,    // shifting in the channel word
        PH_CONV,    // binary search, MSB-first stream
        PH_TAIL,    // LSB-first replay or LSB hold
        PH_DONE     // transaction over, waiting for chip select high
    } sar_phase_t;

endpackage

// File: rtl/sar_addr_decode.sv
// Module: channel-word shift register and multiplexer decode.
// Shifts the bits that follow the start bit MSB-first. The first bit is the
// single-ended flag, then the odd flag, then the select bits. It turns them
// into a positive and a negative channel index.
// Assumes: CH_W >= 2 (at least four channels); shift_en is high for exactly
// CH_W+1 edges per transaction; clr_n clears synchronously.
module sar_addr_decode #(
    parameter int CH_W = 3
) (
    input  logic            clk,
    input  logic            clr_n,
    input  logic            shift_en,
    input  logic            di,
    output logic            single_end,
    output logic [CH_W-1:0] pos_ch,
    output logic [CH_W-1:0] neg_ch
);
    localparam int ADDR_W = CH_W + 1;

    logic [ADDR_W-1:0] word_q;
    logic              odd_bit;
    logic [CH_W-2:0]   sel_bits;

    // Capture one address bit per enabled rising edge.
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            word_q <= '0;
        end else if (shift_en) begin
            word_q <= {word_q[ADDR_W-2:0], di};
        end
    end

    assign single_end = word_q[ADDR_W-1];
    assign odd_bit    = word_q[ADDR_W-2];
    assign sel_bits   = word_q[ADDR_W-3:0];

    // Map the word onto the multiplexer: pairs are adjacent channels.
    always_comb begin
        pos_ch = {sel_bits, odd_bit};
        neg_ch = single_end ? '0 : {sel_bits, ~odd_bit};
    end

endmodule

// File: rtl/sar_search.sv
// Module: successive-approximation register.
// load presets the trial code to mid-scale. Each step keeps or drops the
// bit under test according to the comparator and sets the next lower bit.
// After RES_W steps the code holds the final result.
// Assumes: load and step are never high together; comp_hi refers to the
// trial code presented during the cycle before the step edge.
module sar_search #(
    parameter int RES_W = 8
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load,
    input  logic             step,
    input  logic             comp_hi,
    output logic [RES_W-1:0] code
);
    localparam logic [RES_W-1:0] MID = {1'b1, {(RES_W-1){1'b0}}};

    logic [RES_W-1:0] code_q;
    logic [RES_W-1:0] mask_q;

    // Binary search: mask_q marks the bit decided on the next step.
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            code_q <= '0;
            mask_q <= '0;
        end else if (load) begin
            code_q <= MID;
            mask_q <= MID;
        end else if (step) begin
            code_q <= (comp_hi ? code_q : (code_q & ~mask_q)) | (mask_q >> 1);
            mask_q <= mask_q >> 1;
        end
    end

    assign code = code_q;

endmodule

// File: rtl/sar_out_stage.sv
// Module: falling-edge retiming of the serial data output.
// Moves the bit and enable decided on the rising edge to the following
// falling edge, so that the host can sample on its next rising edge.
// Chip select high floats the line at once.
// Assumes: rst_n is synchronous to the falling edge as well.
module sar_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic bit_d,
    input  logic en_d,
    output logic dout,
    output logic dout_oe
);
    logic bit_q;
    logic en_q;

    // Half-cycle retime of the output value and its enable.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            bit_q <= 1'b0;
            en_q  <= 1'b0;
        end else begin
            bit_q <= bit_d;
            en_q  <= en_d;
        end
    end

    assign dout_oe = en_q & ~cs_n;
    assign dout    = bit_q & dout_oe;

endmodule

// File: rtl/sar_serial_adc.sv
// Module: serial-controlled successive-approximation converter core (top).
// It waits for a start bit and shifts in the channel word. It runs RES_W
// search steps, streaming each decided bit MSB-first after one low settling
// period, and then replays the result LSB-first. The four-channel build
// replays at once; wider builds wait for lsb_hold to go low.
// Assumes: NUM_CH is a power of two >= 4; analog parts are outside the core.
module sar_serial_adc #(
    parameter int NUM_CH = 8,
    parameter int RES_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cs_n,
    input  logic                      di,
    input  logic                      lsb_hold,
    input  logic                      comp_hi,
    output logic                      dout,
    output logic                      dout_oe,
    output logic                      busy,
    output logic                      mux_single,
    output logic [$clog2(NUM_CH)-1:0] mux_pos,
    output logic [$clog2(NUM_CH)-1:0] mux_neg,
    output logic [RES_W-1:0]          trial
);
    import sar_adc_pkg::*;

    localparam int CH_W     = $clog2(NUM_CH);
    localparam int ADDR_W   = CH_W + 1;
    localparam int IDX_W    = $clog2(RES_W);
    localparam int CNT_W    = $clog2(RES_W + ADDR_W + 1);
    localparam bit AUTO_LSB = (NUM_CH <= 4);

    sar_phase_t       phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             bit_q;
    logic             en_q;
    logic             clr_n;
    logic             addr_last;
    logic             advance;
    logic [IDX_W-1:0] tail_idx;
    logic [RES_W-1:0] code;

    assign clr_n     = rst_n & ~cs_n;
    assign addr_last = (phase_q == PH_ADDR) && (cnt_q == CNT_W'(ADDR_W - 1));
    assign tail_idx  = cnt_q[IDX_W-1:0];

    // Replay pacing: automatic for the small build, pin-gated otherwise.
    generate
        if (AUTO_LSB) begin : g_auto_tail
            assign advance = 1'b1;
        end else begin : g_held_tail
            assign advance = ~lsb_hold;
        end
    endgenerate

    sar_addr_decode #(.CH_W(CH_W)) u_addr (
        .clk        (clk),
        .clr_n      (clr_n),
        .shift_en   (phase_q == PH_ADDR),
        .di         (di),
        .single_end (mux_single),
        .pos_ch     (mux_pos),
        .neg_ch     (mux_neg)
    );

    sar_search #(.RES_W(RES_W)) u_search (
        .clk     (clk),
        .clr_n   (clr_n),
        .load    (addr_last),
        .step    (phase_q == PH_CONV),
        .comp_hi (comp_hi),
        .code    (code)
    );

    // Transaction sequencer: phase, bit counter, busy flag, output bit.
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            busy_q  <= 1'b0;
            bit_q   <= 1'b0;
            en_q    <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (di) begin
                        phase_q <= PH_ADDR;
                        cnt_q   <= '0;
                    end
                end
                PH_ADDR: begin
                    if (addr_last) begin
                        phase_q <= PH_CONV;
                        cnt_q   <= '0;
                        busy_q  <= 1'b1;
                        bit_q   <= 1'b0;
                        en_q    <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_CONV: begin
                    bit_q <= comp_hi;
                    if (cnt_q == CNT_W'(RES_W - 1)) begin
                        phase_q <= PH_TAIL;
                        busy_q  <= 1'b0;
                        cnt_q   <= CNT_W'(1);
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_TAIL: begin
                    if (advance) begin
                        if (cnt_q == CNT_W'(RES_W)) begin
                            phase_q <= PH_DONE;
                            bit_q   <= 1'b0;
                            en_q    <= 1'b0;
                        end else begin
                            bit_q <= code[tail_idx];
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: begin
                    phase_q <= PH_DONE;
                end
            endcase
        end
    end

    sar_out_stage u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .bit_d   (bit_q),
        .en_d    (en_q),
        .dout    (dout),
        .dout_oe (dout_oe)
    );

    assign busy  = busy_q;
    assign trial = code;

endmodule

// File: rtl/sar_serial_adc_chk.sv
// Module: temporal checks on the converter core, attached by bind.
// Assumes: sampled on rising clock edges; all checks are off during reset.
module sar_serial_adc_chk #(
    parameter int RES_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             busy,
    input logic             dout,
    input logic             dout_oe,
    input logic [RES_W-1:0] trial
);
    localparam logic [RES_W-1:0] MID = {1'b1, {(RES_W-1){1'b0}}};

    // R1: chip select high empties the core by the next edge.
    p_cs_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!busy && trial == '0 && !dout_oe));

    // R5: a search always begins at mid-scale.
    p_trial_mid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> trial == MID);

    // R5: each search step touches at most two bits of the trial code.
    p_search_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $countones(trial ^ $past(trial)) <= 2);

    // R6: the settling period drives a low.
    p_settle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (dout_oe && !dout));

    // R7: at the end of the search the line is still driven with the LSB.
    p_lsb_driven_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(rst_n) && !$past(cs_n) && !cs_n) |-> dout_oe);

endmodule

bind sar_serial_adc sar_serial_adc_chk #(.RES_W(RES_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .busy    (busy),
    .dout    (dout),
    .dout_oe (dout_oe),
    .trial   (trial)
);

// File: tb/sar_serial_adc_tb.sv
module sar_serial_adc_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs8_n = 1'b1;
    logic cs4_n = 1'b1;
    logic di = 1'b0;
    logic lsb_hold = 1'b1;
    logic comp8, comp4;
    logic dout8, oe8, busy8, single8;
    logic dout4, oe4, busy4, single4;
    logic [2:0] pos8, neg8;
    logic [1:0] pos4, neg4;
    logic [7:0] trial8, trial4;

    int v8[8];
    int v4[4];
    int vcom;
    int vin8, vin4;
    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sar_serial_adc #(.NUM_CH(8), .RES_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs8_n), .di(di), .lsb_hold(lsb_hold),
        .comp_hi(comp8), .dout(dout8), .dout_oe(oe8), .busy(busy8),
        .mux_single(single8), .mux_pos(pos8), .mux_neg(neg8), .trial(trial8)
    );

    sar_serial_adc #(.NUM_CH(4), .RES_W(8)) u_dut4 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs4_n), .di(di), .lsb_hold(lsb_hold),
        .comp_hi(comp4), .dout(dout4), .dout_oe(oe4), .busy(busy4),
        .mux_single(single4), .mux_pos(pos4), .mux_neg(neg4), .trial(trial4)
    );

    // Analog model: 8-channel single-ended is referred to the common input,
    // 4-channel single-ended to ground.
    always_comb begin
        vin8 = single8 ? (v8[pos8] - vcom) : (v8[pos8] - v8[neg8]);
        vin4 = single4 ? v4[pos4] : (v4[pos4] - v4[neg4]);
    end
    assign comp8 = (vin8 >= int'(trial8));
    assign comp4 = (vin4 >= int'(trial4));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    function automatic int clamp(input int x);
        return (x < 0) ? 0 : ((x > 255) ? 255 : x);
    endfunction

    function automatic bit g_dout(input bit is4); return is4 ? dout4 : dout8; endfunction
    function automatic bit g_oe(input bit is4);   return is4 ? oe4 : oe8;     endfunction
    function automatic bit g_busy(input bit is4); return is4 ? busy4 : busy8; endfunction
    function automatic int g_trial(input bit is4); return is4 ? int'(trial4) : int'(trial8); endfunction

    // One full transaction with a given address word and LSB hold time.
    task automatic run_conv(input bit is4, input bit sgl, input bit odd, input int sel, input int hold);
        int pos, neg, vin, expv, got;
        pos = sel * 2 + int'(odd);
        neg = sel * 2 + int'(!odd);
        if (is4) vin = sgl ? v4[pos] : v4[pos] - v4[neg];
        else     vin = sgl ? v8[pos] - vcom : v8[pos] - v8[neg];
        expv = clamp(vin);
        lsb_hold = 1'b1;
        di = 1'b0;
        if (is4) cs4_n = 1'b0; else cs8_n = 1'b0;
        repeat (2) step();
        chk(!g_busy(is4) && !g_oe(is4), "R2 zeros before start", int'(g_busy(is4)), 0);
        di = 1'b1; step();
        di = sgl; step();
        di = odd; step();
        if (is4) begin
            di = sel[0]; step();
        end else begin
            di = sel[1]; step();
            di = sel[0]; step();
        end
        chk(g_busy(is4), "R5 busy rises", int'(g_busy(is4)), 1);
        chk(g_trial(is4) == 128, "R5 trial mid-scale", g_trial(is4), 128);
        chk(g_oe(is4) && !g_dout(is4), "R6 settle low", int'(g_oe(is4)) * 2 + int'(g_dout(is4)), 2);
        if (is4) begin
            chk(int'(single4) == int'(sgl) && int'(pos4) == pos && (sgl || int'(neg4) == neg),
                "R4 mux decode", int'(pos4) * 8 + int'(neg4), pos * 8 + neg);
        end else begin
            chk(int'(single8) == int'(sgl) && int'(pos8) == pos && (sgl || int'(neg8) == neg),
                "R3 mux decode", int'(pos8) * 8 + int'(neg8), pos * 8 + neg);
        end
        got = 0;
        for (int i = 0; i < 8; i++) begin
            di = 1'($urandom);  // R9: noise on di during the search
            step();
            got = got * 2 + int'(g_dout(is4));
            chk(g_dout(is4) == expv[7 - i], "R7 MSB-first bit", int'(g_dout(is4)), expv[7 - i]);
            chk(g_busy(is4) == (i < 7), "R5 busy length", int'(g_busy(is4)), int'(i < 7));
        end
        chk(got == expv, "R8 result value", got, expv);
        if (is4) begin
            for (int j = 1; j < 8; j++) begin
                di = 1'($urandom);
                step();
                chk(g_dout(is4) == expv[j] && g_oe(is4), "R10 LSB-first bit", int'(g_dout(is4)), expv[j]);
            end
            step();
            chk(!g_oe(is4), "R10 float after replay", int'(g_oe(is4)), 0);
        end else begin
            for (int h = 0; h < hold; h++) begin
                di = 1'($urandom);
                step();
                chk(g_dout(is4) == expv[0] && g_oe(is4), "R11 LSB held", int'(g_dout(is4)), expv[0]);
            end
            lsb_hold = 1'b0;
            for (int j = 1; j < 8; j++) begin
                di = 1'($urandom);
                step();
                chk(g_dout(is4) == expv[j] && g_oe(is4), "R11 LSB-first bit", int'(g_dout(is4)), expv[j]);
            end
            step();
            chk(!g_oe(is4), "R11 float after replay", int'(g_oe(is4)), 0);
        end
        di = 1'b0;
        cs8_n = 1'b1;
        cs4_n = 1'b1;
        step();
        chk(!g_oe(is4) && !g_busy(is4) && g_trial(is4) == 0, "R1 idle after deselect",
            g_trial(is4), 0);
    endtask

    task automatic set_levels(input int pass);
        for (int c = 0; c < 8; c++) begin
            case (pass)
                0: v8[c] = int'($urandom_range(255, 0));
                1: v8[c] = int'($urandom_range(200, 0));
                default: v8[c] = (c % 2 == 0) ? 255 : 0;
            endcase
        end
        for (int c = 0; c < 4; c++) v4[c] = v8[c + 4];
        vcom = (pass == 0) ? int'($urandom_range(60, 0)) : ((pass == 1) ? 255 : 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        set_levels(0);
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk(!oe8 && !busy8 && trial8 == 0, "R1 reset state 8ch", int'(trial8), 0);
        chk(!oe4 && !busy4 && trial4 == 0, "R1 reset state 4ch", int'(trial4), 0);

        // R3 / R8 / R11: every 8-channel address word, three level patterns.
        for (int pass = 0; pass < 3; pass++) begin
            set_levels(pass);
            for (int w = 0; w < 16; w++)
                run_conv(1'b0, w[3], w[2], w % 4, w % 3 * 2);
        end
        // R4 / R10: every 4-channel address word.
        for (int pass = 0; pass < 3; pass++) begin
            set_levels(pass);
            for (int w = 0; w < 8; w++)
                run_conv(1'b1, w[2], w[1], w % 2, 0);
        end

        // R1: no second conversion without a chip-select cycle.
        set_levels(0);
        lsb_hold = 1'b0;
        cs8_n = 1'b0;
        di = 1'b1; step();
        di = 1'b1; step();
        repeat (3) begin di = 1'b0; step(); end
        repeat (24) begin di = 1'b0; step(); end
        chk(!oe8 && !busy8, "R1 transaction finished", int'(oe8), 0);
        di = 1'b1; step();
        for (int k = 0; k < 6; k++) begin
            di = 1'($urandom);
            step();
            chk(!busy8 && !oe8, "R1 no restart without deselect", int'(busy8), 0);
        end
        cs8_n = 1'b1; di = 1'b0; step();

        // R1: abort in mid-search.
        cs8_n = 1'b0;
        di = 1'b1; step();
        repeat (4) begin di = 1'b1; step(); end
        repeat (3) step();
        chk(busy8 && oe8, "R1 search under way", int'(busy8), 1);
        cs8_n = 1'b1;
        #1;
        chk(!oe8, "R1 float on deselect", int'(oe8), 0);
        step();
        chk(!busy8 && trial8 == 0, "R1 cleared after abort", int'(trial8), 0);

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule